// File: doc/BRIEF.md
# Waveform Timer Channel

This block is one counter channel that builds two waveform outputs from a free-running or reloading count. A count-enable strobe advances the counter by one step. Four counting modes are available: plain up counting, up counting that returns to zero after the C compare value, up-down counting between zero and the counter's maximum, and up-down counting between zero and the C compare value. After each step the new count is compared against three compare values A, B and C.

Each output has four events that can act on it: its own compare match (A for output A, B for output B), the C match, an edge on a selected external event line, and a software trigger command. Each event has a 2-bit action field: none, set, clear or toggle. The channel can also be told to pause or switch off its counting when C matches. A software trigger, or an external edge when enabled, restarts the count at zero. The channel is controlled through a small register port. Clock selection and input capture are handled outside the block.

Top module: `wavetimer_ch`

## Requirements
- R1: After reset the count is 0, both outputs are low, the channel is not running, and the mode and compare registers read 0.
- R2: Writing the command word (address 0) with bit 0 starts the channel and bit 1 stops it, and stop wins when both are set. The count moves only on a clock where the strobe is high and the channel is running.
- R3: With wave select (mode bits [1:0]) equal to 0, each step adds one and the count wraps from the all-ones value to 0.
- R4: With wave select 2, a step taken while the count is at or above C loads 0. Any other step adds one, so the count period is C+1 steps.
- R5: With wave select 1 or 3, the count rises to a top value and then falls to 0, turning at both ends. The top value is the all-ones value for select 1 and C for select 3.
- R6: When a step makes the new count equal to A, B or C, that compare event fires in the same clock. Actions are coded 0 none, 1 set, 2 clear, 3 toggle. Output A takes its own match from mode bits [9:8], C match from [11:10], external event from [13:12] and software trigger from [15:14]. Output B uses [17:16], [19:18], [21:20] and [23:22] in the same order.
- R7: Mode bit 2 set makes a C match pause counting until the next trigger or start command. Mode bit 3 set makes a C match switch the channel off, and only a start command turns it back on.
- R8: A software trigger (command bit 2), or an external event while mode bit 6 is set, loads 0 into the count and sets the direction to up. No compare event fires on that clock. With mode bit 6 clear, an external event leaves the count unchanged.
- R9: The external event line is chosen from the source inputs by mode bits [25:24]. Mode bits [5:4] pick the edge: 0 none, 1 rising, 2 falling, 3 both. Edges on source lines that are not selected have no effect.
- R10: When several events with actions reach the same output in one clock, one action is applied. The order from highest is software trigger, then external event, then C match, then the output's own match. An event whose action is none does not hide a lower one.
- R11: Reads return status at address 0 (bit 16 running, bit 17 output A, bit 18 output B), mode at 1, A, B and C at 2, 3 and 4, and the count at 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| tick_i | input | 1 | Count-enable strobe |
| evt_src_i | input | SRC_N | External event source lines |
| wave_a_o | output | 1 | Waveform output A |
| wave_b_o | output | 1 | Waveform output B |

## Verification
The hardest cases to reach are the ones where several events land on the same output in a single clock. The bench gets there by raising a selected source line on the same clock edge that the software trigger command is written. It also places A and C at the same value, so both compare matches come from one step. The turning points of the all-ones up-down mode and the wrap in plain up mode are reached by holding the strobe high for a full count span. The pause and switch-off behaviour on C is checked by issuing more strobes after the match and then reading the count back.

// File: rtl/wt_pkg.sv
package wt_pkg;
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2,
      ACT_TGL  = 2'd3
   } wt_act_e;

   typedef struct packed {
      logic [5:0] rsv_hi;
      logic [1:0] evt_src;
      wt_act_e    b_sw;
      wt_act_e    b_ext;
      wt_act_e    b_c;
      wt_act_e    b_cmp;
      wt_act_e    a_sw;
      wt_act_e    a_ext;
      wt_act_e    a_c;
      wt_act_e    a_cmp;
      logic       rsv_lo;
      logic       evt_trg_en;
      logic [1:0] evt_edge;
      logic       dis_on_c;
      logic       stop_on_c;
      logic [1:0] wave_sel;
   } wt_mode_t;

   localparam int unsigned AD_CMD  = 0;
   localparam int unsigned AD_MODE = 1;
   localparam int unsigned AD_CMPA = 2;
   localparam int unsigned AD_CNT  = 5;
   localparam int unsigned NUM_CMP = 3;
   localparam int unsigned NUM_REQ = 4;
endpackage

// File: rtl/wt_count_core.sv
module wt_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             trig_i,
   input  logic             en_cmd_i,
   input  logic             dis_cmd_i,
   input  logic             updown_i,
   input  logic             rc_trig_i,
   input  logic [CNT_W-1:0] rc_i,
   input  logic             c_hit_i,
   input  logic             stop_on_c_i,
   input  logic             dis_on_c_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o,
   output logic             step_o,
   output logic             running_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q, cnt_n, top;
   logic             up_q, up_n;
   logic             en_q, halt_q;

   assign running_o = en_q & ~halt_q;
   assign step_o    = running_o & tick_i & ~trig_i;
   assign top       = rc_trig_i ? rc_i : CNT_MAX;

   always_comb begin
      cnt_n = cnt_q;
      up_n  = up_q;
      if (trig_i) begin
         cnt_n = '0;
         up_n  = 1'b1;
      end else if (step_o) begin
         if (!updown_i) begin
            up_n = 1'b1;
            if (rc_trig_i && (cnt_q >= rc_i)) cnt_n = '0;
            else                              cnt_n = cnt_q + 1'b1;
         end else if (up_q) begin
            if (cnt_q >= top) begin
               if (cnt_q != '0) begin
                  cnt_n = cnt_q - 1'b1;
                  up_n  = 1'b0;
               end
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end else begin
            if (cnt_q == '0) begin
               up_n  = 1'b1;
               cnt_n = (top != '0) ? CNT_W'(1) : '0;
            end else begin
               cnt_n = cnt_q - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         up_q   <= 1'b1;
         en_q   <= 1'b0;
         halt_q <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         up_q  <= up_n;
         if (dis_cmd_i)                    en_q <= 1'b0;
         else if (en_cmd_i)                en_q <= 1'b1;
         else if (c_hit_i && dis_on_c_i)   en_q <= 1'b0;
         if (en_cmd_i || trig_i)           halt_q <= 1'b0;
         else if (c_hit_i && stop_on_c_i)  halt_q <= 1'b1;
      end
   end

   assign cnt_o     = cnt_q;
   assign cnt_nxt_o = cnt_n;
endmodule

// File: rtl/wt_evt_edge.sv
module wt_evt_edge #(
   parameter int SRC_N = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SRC_N-1:0] src_i,
   input  logic [1:0]       sel_i,
   input  logic [1:0]       edge_i,
   output logic             evt_o
);
   logic [SRC_N-1:0] prev_q;
   logic [3:0]       cur_pad, prev_pad;
   logic             cur, prv;

   always_comb begin
      cur_pad  = '0;
      prev_pad = '0;
      cur_pad[SRC_N-1:0]  = src_i;
      prev_pad[SRC_N-1:0] = prev_q;
      cur = cur_pad[sel_i];
      prv = prev_pad[sel_i];
      unique case (edge_i)
         2'd1:    evt_o = cur & ~prv;
         2'd2:    evt_o = ~cur & prv;
         2'd3:    evt_o = cur ^ prv;
         default: evt_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= src_i;
   end
endmodule

// File: rtl/wt_out_action.sv
module wt_out_action
   import wt_pkg::*;
#(
   parameter int REQ_N = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [REQ_N-1:0]      req_i,
   input  logic [REQ_N-1:0][1:0] act_i,
   output logic                  q_o
);
   wt_act_e sel;
   logic    q_q, q_n;

   always_comb begin
      sel = ACT_NONE;
      for (int i = 0; i < REQ_N; i++) begin
         if (req_i[i] && (wt_act_e'(act_i[i]) != ACT_NONE)) sel = wt_act_e'(act_i[i]);
      end
      unique case (sel)
         ACT_SET: q_n = 1'b1;
         ACT_CLR: q_n = 1'b0;
         ACT_TGL: q_n = ~q_q;
         default: q_n = q_q;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) q_q <= 1'b0;
      else         q_q <= q_n;
   end

   assign q_o = q_q;
endmodule

// File: rtl/wavetimer_ch.sv
module wavetimer_ch
   import wt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int SRC_N  = 4,
   parameter int ADDR_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   input  logic              tick_i,
   input  logic [SRC_N-1:0]  evt_src_i,
   output logic              wave_a_o,
   output logic              wave_b_o
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("wavetimer_ch: CNT_W must lie in 2..32");
   end
   if (SRC_N < 1 || SRC_N > 4) begin : g_bad_src_n
      $error("wavetimer_ch: SRC_N must lie in 1..4");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("wavetimer_ch: ADDR_W must be at least 3");
   end

   wt_mode_t         mode_q;
   logic [CNT_W-1:0] cmp_q [NUM_CMP];
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic [NUM_CMP-1:0] hit;
   logic             step, running, trig, sw_trg, ext_evt;
   logic             en_cmd, dis_cmd, cmd_wr;
   logic [1:0]       wave_q;
   logic [1:0][NUM_REQ-1:0][1:0] acts;
   logic [1:0][NUM_REQ-1:0]      reqs;

   assign cmd_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(AD_CMD));
   assign en_cmd  = cmd_wr & reg_wdata_i[0];
   assign dis_cmd = cmd_wr & reg_wdata_i[1];
   assign sw_trg  = cmd_wr & reg_wdata_i[2];
   assign trig    = sw_trg | (ext_evt & mode_q.evt_trg_en);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= '0;
         for (int k = 0; k < NUM_CMP; k++) cmp_q[k] <= '0;
      end else if (reg_wr_i) begin
         if (reg_addr_i == ADDR_W'(AD_MODE)) mode_q <= wt_mode_t'(reg_wdata_i);
         for (int k = 0; k < NUM_CMP; k++) begin
            if (reg_addr_i == ADDR_W'(AD_CMPA + k)) cmp_q[k] <= reg_wdata_i[CNT_W-1:0];
         end
      end
   end

   wt_evt_edge #(.SRC_N(SRC_N)) u_evt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (evt_src_i),
      .sel_i  (mode_q.evt_src),
      .edge_i (mode_q.evt_edge),
      .evt_o  (ext_evt)
   );

   wt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .trig_i      (trig),
      .en_cmd_i    (en_cmd),
      .dis_cmd_i   (dis_cmd),
      .updown_i    (mode_q.wave_sel[0]),
      .rc_trig_i   (mode_q.wave_sel[1]),
      .rc_i        (cmp_q[2]),
      .c_hit_i     (hit[2]),
      .stop_on_c_i (mode_q.stop_on_c),
      .dis_on_c_i  (mode_q.dis_on_c),
      .cnt_o       (cnt),
      .cnt_nxt_o   (cnt_nxt),
      .step_o      (step),
      .running_o   (running)
   );

   always_comb begin
      for (int k = 0; k < NUM_CMP; k++) hit[k] = step && (cnt_nxt == cmp_q[k]);
   end

   // request order, lowest priority first: own match, C match, external, software
   always_comb begin
      acts[0] = {mode_q.a_sw, mode_q.a_ext, mode_q.a_c, mode_q.a_cmp};
      acts[1] = {mode_q.b_sw, mode_q.b_ext, mode_q.b_c, mode_q.b_cmp};
      reqs[0] = {sw_trg, ext_evt, hit[2], hit[0]};
      reqs[1] = {sw_trg, ext_evt, hit[2], hit[1]};
   end

   for (genvar g = 0; g < 2; g++) begin : g_out
      wt_out_action #(.REQ_N(NUM_REQ)) u_act (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .req_i  (reqs[g]),
         .act_i  (acts[g]),
         .q_o    (wave_q[g])
      );
   end

   assign wave_a_o = wave_q[0];
   assign wave_b_o = wave_q[1];

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         ADDR_W'(AD_CMD):      reg_rdata_o = {13'd0, wave_q[1], wave_q[0], running, 16'd0};
         ADDR_W'(AD_MODE):     reg_rdata_o = mode_q;
         ADDR_W'(AD_CMPA):     reg_rdata_o = 32'(cmp_q[0]);
         ADDR_W'(AD_CMPA + 1): reg_rdata_o = 32'(cmp_q[1]);
         ADDR_W'(AD_CMPA + 2): reg_rdata_o = 32'(cmp_q[2]);
         ADDR_W'(AD_CNT):      reg_rdata_o = 32'(cnt);
         default:              reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/wt_chk.sv
module wt_chk #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_i,
   input logic              trig,
   input logic              step,
   input logic              running,
   input logic              sw_trg,
   input logic              ext_evt,
   input logic [2:0]        hit,
   input logic [1:0]        wave_sel,
   input logic [CNT_W-1:0]  rc,
   input logic [CNT_W-1:0]  cnt,
   input logic              wave_a_o,
   input logic              wave_b_o,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [31:0]       reg_rdata_o
);
   assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !trig) |=> $stable(cnt));

   assert_halt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!running && !trig) |=> $stable(cnt));

   assert_rc_return_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wave_sel == 2'd2 && step && cnt == rc) |=> (cnt == '0));

   assert_trig_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig |=> (cnt == '0));

   assert_quiet_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sw_trg && !ext_evt && hit == 3'b000) |=> ($stable(wave_a_o) && $stable(wave_b_o)));

   assert_mirror_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_addr_i == '0) |-> (reg_rdata_o[17] == wave_a_o && reg_rdata_o[18] == wave_b_o));
endmodule

bind wavetimer_ch wt_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .tick_i      (tick_i),
   .trig        (trig),
   .step        (step),
   .running     (running),
   .sw_trg      (sw_trg),
   .ext_evt     (ext_evt),
   .hit         (hit),
   .wave_sel    (mode_q.wave_sel),
   .rc          (cmp_q[2]),
   .cnt         (cnt),
   .wave_a_o    (wave_a_o),
   .wave_b_o    (wave_b_o),
   .reg_addr_i  (reg_addr_i),
   .reg_rdata_o (reg_rdata_o)
);

// File: tb/tb_wavetimer_ch.sv
module tb_wavetimer_ch;
   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tick = 1'b0;
   logic [3:0]  src = '0;
   logic        wave_a, wave_b;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   wavetimer_ch dut (
      .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .tick_i(tick),
      .evt_src_i(src), .wave_a_o(wave_a), .wave_b_o(wave_b)
   );

   function automatic logic [31:0] mk(input int ws, input int stp, input int dis,
      input int edg, input int trg, input int a_cmp, input int a_c, input int a_ext,
      input int a_sw, input int b_cmp, input int b_c, input int b_ext, input int b_sw,
      input int sel);
      return 32'(ws | (stp << 2) | (dis << 3) | (edg << 4) | (trg << 6) |
                 (a_cmp << 8) | (a_c << 10) | (a_ext << 12) | (a_sw << 14) |
                 (b_cmp << 16) | (b_c << 18) | (b_ext << 20) | (b_sw << 22) | (sel << 24));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_ni = 1'b0; reg_wr = 1'b0; tick = 1'b0; src = '0;
      repeat (2) @(negedge clk);
      rst_ni = 1'b1;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      reg_addr = 3'(a);
      #1;
      v = reg_rdata;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      rd(5, v); chk("R1 count", v, 0);
      rd(0, v); chk("R1 status", v, 0);
      rd(1, v); chk("R1 mode", v, 0);
      rd(4, v); chk("R1 cmp C", v, 0);
      chk("R1 outputs", {wave_a, wave_b}, 0);
   endtask

   task automatic t_up_basic();
      logic [31:0] v;
      do_reset();
      wr(2, 3); wr(3, 5);
      wr(1, mk(0,0,0,0,0, 1,0,0,0, 3,0,0,0, 0));
      rd(2, v); chk("R11 cmp A readback", v, 3);
      wr(0, 1);
      rd(0, v); chk("R2 running after start", (v >> 16) & 1, 1);
      ticks(3);
      rd(5, v); chk("R3 count after 3 steps", v, 3);
      chk("R6 A set on A match", wave_a, 1);
      rd(0, v); chk("R11 status mirror A", (v >> 17) & 1, 1);
      ticks(2);
      chk("R6 B toggle on B match", wave_b, 1);
      repeat (5) @(negedge clk);
      rd(5, v); chk("R2 no strobe no step", v, 5);
      wr(0, 3);
      rd(0, v); chk("R2 stop wins over start", (v >> 16) & 1, 0);
      ticks(4);
      rd(5, v); chk("R2 stopped ignores strobe", v, 5);
   endtask

   task automatic t_wrap();
      logic [31:0] v;
      do_reset();
      wr(0, 1);
      ticks(65535);
      rd(5, v); chk("R3 count at all-ones", v, 65535);
      ticks(1);
      rd(5, v); chk("R3 wrap to zero", v, 0);
   endtask

   task automatic t_up_rc();
      logic [31:0] v;
      do_reset();
      wr(4, 4);
      wr(1, mk(2,0,0,0,0, 0,3,0,0, 0,1,0,0, 0));
      wr(0, 1);
      ticks(4);
      rd(5, v); chk("R4 count reaches C", v, 4);
      chk("R6 A toggle on C match", wave_a, 1);
      chk("R6 B set on C match", wave_b, 1);
      ticks(1);
      rd(5, v); chk("R4 return to zero", v, 0);
      ticks(5);
      rd(5, v); chk("R4 period C+1", v, 0);
      chk("R6 A toggled back", wave_a, 0);
   endtask

   task automatic t_updown();
      logic [31:0] v;
      int exp_seq [8] = '{1, 2, 3, 2, 1, 0, 1, 2};
      do_reset();
      wr(4, 3);
      wr(1, mk(3,0,0,0,0, 0,0,0,0, 0,0,0,0, 0));
      wr(0, 1);
      for (int i = 0; i < 8; i++) begin
         ticks(1);
         rd(5, v); chk("R5 up-down to C", v, 32'(exp_seq[i]));
      end
      do_reset();
      wr(1, mk(1,0,0,0,0, 0,0,0,0, 0,0,0,0, 0));
      wr(0, 1);
      ticks(65535);
      rd(5, v); chk("R5 up-down reaches all-ones", v, 65535);
      ticks(2);
      rd(5, v); chk("R5 turn down at all-ones", v, 65533);
   endtask

   task automatic t_stop_dis();
      logic [31:0] v;
      do_reset();
      wr(4, 2);
      wr(1, mk(2,1,0,0,0, 0,0,0,0, 0,0,0,0, 0));
      wr(0, 1);
      ticks(2);
      rd(0, v); chk("R7 paused on C", (v >> 16) & 1, 0);
      ticks(3);
      rd(5, v); chk("R7 pause holds count", v, 2);
      wr(0, 4);
      rd(5, v); chk("R8 sw trigger zeroes count", v, 0);
      ticks(1);
      rd(5, v); chk("R7 trigger resumes", v, 1);
      do_reset();
      wr(4, 2);
      wr(1, mk(0,0,1,0,0, 0,0,0,0, 0,0,0,0, 0));
      wr(0, 1);
      ticks(2);
      wr(0, 4);
      ticks(2);
      rd(5, v); chk("R7 switched off ignores trigger restart", v, 0);
      wr(0, 1);
      ticks(1);
      rd(5, v); chk("R7 start command revives", v, 1);
   endtask

   task automatic t_ext();
      logic [31:0] v;
      do_reset();
      wr(1, mk(0,0,0,1,1, 0,0,1,0, 0,0,3,0, 2));
      wr(0, 1);
      ticks(5);
      @(negedge clk); src[2] = 1'b1;
      @(negedge clk);
      rd(5, v); chk("R8 ext trigger zeroes count", v, 0);
      chk("R9 ext rise sets A", wave_a, 1);
      chk("R9 ext rise toggles B", wave_b, 1);
      src[2] = 1'b0;
      @(negedge clk);
      chk("R9 falling ignored on rise setting", wave_b, 1);
      wr(1, mk(0,0,0,3,1, 0,0,1,0, 0,0,3,0, 2));
      @(negedge clk); src[2] = 1'b1;
      @(negedge clk);
      chk("R9 both-edge toggles B", wave_b, 0);
      src[0] = 1'b1;
      @(negedge clk);
      chk("R9 unselected line ignored", wave_b, 0);
      wr(1, mk(0,0,0,3,0, 0,0,1,0, 0,0,0,0, 2));
      ticks(3);
      @(negedge clk); src[2] = 1'b0;
      @(negedge clk);
      rd(5, v); chk("R8 no restart with trigger enable clear", v, 3);
   endtask

   task automatic t_prio();
      logic [31:0] v;
      do_reset();
      wr(1, mk(0,0,0,1,0, 0,0,1,2, 0,0,0,0, 0));
      @(negedge clk); src[0] = 1'b1;
      @(negedge clk); src[0] = 1'b0;
      chk("R10 ext alone sets A", wave_a, 1);
      @(negedge clk);
      src[0] = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd4;
      @(negedge clk); reg_wr = 1'b0;
      chk("R10 sw clear beats ext set", wave_a, 0);
      do_reset();
      wr(1, mk(0,0,0,1,0, 0,0,1,0, 0,0,0,0, 0));
      @(negedge clk);
      src[0] = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd4;
      @(negedge clk); reg_wr = 1'b0;
      chk("R10 none on sw does not hide ext", wave_a, 1);
      do_reset();
      wr(2, 2); wr(4, 2);
      wr(1, mk(0,0,0,0,0, 2,1,0,0, 0,0,0,0, 0));
      wr(0, 1);
      ticks(2);
      chk("R10 C set beats A clear", wave_a, 1);
   endtask

   initial begin
      t_reset();
      t_up_basic();
      t_wrap();
      t_up_rc();
      t_updown();
      t_stop_dis();
      t_ext();
      t_prio();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
      $finish;
   end
endmodule